// File: doc/BRIEF.md
# DMA Descriptor Ring Status Controller

This block keeps the index and interrupt state for one copy channel that owns two descriptor rings. One ring carries outbound buffers (the send ring) and one carries posted receive buffers (the receive ring). Software posts work by writing a new write index for either ring through a 32-bit register port. The hardware side reports each finished descriptor with a one-cycle consume strobe, and that strobe moves the matching read index forward by one. Both rings hold a power-of-two number of entries, so every index step and every distance is plain modular arithmetic on the index width.

From the two indices of each ring the block derives the ring fill level. It compares that level with a programmable low and high threshold for each ring, and catches write-index updates that would fill the ring completely. It also collects error events reported by the data path. All events land in two sticky status words, one for host events and one for errors. Software clears them by writing ones. Each word has an enable mask, and each masked word drives its own interrupt line. A command register lets software stop the hardware side: once the halt is reported, consume strobes are ignored. A control register holds the maximum receive length and two byte-order enables, and drives them out to the data path.

Top module: `ring_stat_ctrl`

## Requirements
- R1: Register offsets are: send write index 0x3C, receive write index 0x40, send read index 0x44 (read-only), receive read index 0x48 (read-only). Writing a write index that does not overflow the ring stores it. Fill level is (write − read) mod entries, and the index wraps modulo the ring size (send ring 16 entries, receive ring 8 by default).
- R2: A consume strobe moves that ring's read index forward by one, modulo the ring size, when the ring is not empty. On an empty ring the strobe has no effect.
- R3: A write-index update is rejected when the old fill level plus the added entries ((new − old) mod entries) reaches the ring size. The index keeps its old value, and error status bit 5 (send ring) or bit 6 (receive ring) is set.
- R4: Each ring has a threshold register: send at 0x4C, receive at 0x50. The low threshold sits in bits 31:16 and the high threshold in bits 15:0. A change of the fill level from not-above to above the high threshold sets host status bit 1 (send) or bit 3 (receive).
- R5: A change of the fill level from not-below to below the low threshold sets host status bit 2 (send) or bit 4 (receive).
- R6: Every accepted consume on the send ring sets host status bit 0 (copy done).
- R7: Status bits are sticky. Writing 1 to a bit of the host status (0x30) or error status (0x38) clears that bit. Writing 0 leaves it unchanged.
- R8: The host interrupt is the OR of host status bits 4:0 ANDed with the host enables at 0x2C. The error interrupt is the OR of error status bits 10:5 ANDed with the error enables at 0x34, which use the same bit positions.
- R9: The four data-path error inputs set error status bits 7 (input bit 0, receive length over limit), 8 (input bit 1, send length error), 9 (input bit 2, receive address error) and 10 (input bit 3, bus error).
- R10: The control register at 0x10 keeps only the bits under mask 0x0007FFFF. Bits 15:0 drive the maximum receive length, bit 16 the send byte-order enable and bit 17 the receive byte-order enable.
- R11: Command register 0x18: bit 0 is the halt request and bit 3 is the halt status. The halt status follows the request one cycle later. While the halt status is set, consume strobes are ignored.
- R12: After reset every register reads 0, both interrupts are low and halt status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (8) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| src_consume | input | 1 | Send ring descriptor finished |
| dst_consume | input | 1 | Receive ring descriptor finished |
| hw_err | input | 4 | Data-path error pulses, mapped to error status bits 7..10 |
| host_irq | output | 1 | Masked host status interrupt |
| err_irq | output | 1 | Masked error status interrupt |
| max_dst_len | output | 16 | Maximum receive length from control register |
| src_swap_en | output | 1 | Send ring byte-order enable |
| dst_swap_en | output | 1 | Receive ring byte-order enable |
| halted | output | 1 | Halt status |

## Verification
The index and fill-level logic is tested with several kinds of update. Plain forward writes check the basic store. A write that wraps past the top of the index space separates modular arithmetic from plain subtraction. A write that would fill the ring exactly exercises the overflow cut-off at its boundary, and consume strobes on an empty ring show that the read index does not move below the write index. Threshold events are driven both by index changes and by writing new thresholds, which shows that the status bits react to crossings and not to levels. Halt is checked one cycle apart, which separates the request from the reported status.

// File: rtl/ring_stat_pkg.sv
package ring_stat_pkg;
  // register byte offsets
  localparam logic [7:0] OFF_CTRL     = 8'h10;
  localparam logic [7:0] OFF_CMD      = 8'h18;
  localparam logic [7:0] OFF_HOST_IE  = 8'h2C;
  localparam logic [7:0] OFF_HOST_ST  = 8'h30;
  localparam logic [7:0] OFF_ERR_IE   = 8'h34;
  localparam logic [7:0] OFF_ERR_ST   = 8'h38;
  localparam logic [7:0] OFF_SRC_WR   = 8'h3C;
  localparam logic [7:0] OFF_DST_WR   = 8'h40;
  localparam logic [7:0] OFF_SRC_RD   = 8'h44;
  localparam logic [7:0] OFF_DST_RD   = 8'h48;
  localparam logic [7:0] OFF_SRC_WM   = 8'h4C;
  localparam logic [7:0] OFF_DST_WM   = 8'h50;

  localparam int unsigned HOST_W   = 5;   // host status bits 4:0
  localparam int unsigned ERR_W    = 6;   // error status bits 10:5
  localparam int unsigned ERR_LSB  = 5;
  localparam int unsigned CTRL_W   = 19;  // writable control bits
  localparam int unsigned CMD_HALT_BIT = 0;
  localparam int unsigned CMD_STS_BIT  = 3;

  typedef struct packed {
    logic [15:0] lo;
    logic [15:0] hi;
  } wm_t;
endpackage

// File: rtl/rs_ring_track.sv
module rs_ring_track #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_val,
  input  logic          consume,
  input  logic          hold,
  output logic [IW-1:0] wr_idx,
  output logic [IW-1:0] rd_idx,
  output logic [IW-1:0] occ,
  output logic          ovf_evt,
  output logic          pop_evt
);
  logic [IW-1:0] wr_q, wr_d;
  logic [IW-1:0] rd_q, rd_d;
  logic [IW-1:0] added;
  logic [IW:0]   fill_sum;

  // index width equals log2 of the entry count, so truncation is the modulo
  always_comb begin
    occ      = wr_q - rd_q;
    added    = wr_val - wr_q;
    fill_sum = {1'b0, occ} + {1'b0, added};
    ovf_evt  = wr_en && fill_sum[IW];
    pop_evt  = consume && !hold && (occ != '0);
    wr_d     = (wr_en && !ovf_evt) ? wr_val : wr_q;
    rd_d     = pop_evt ? rd_q + 1'b1 : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  assign wr_idx = wr_q;
  assign rd_idx = rd_q;
endmodule

// File: rtl/rs_wm_cross.sv
module rs_wm_cross #(
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] occ,
  input  logic [15:0]   lo_th,
  input  logic [15:0]   hi_th,
  output logic          hi_evt,
  output logic          lo_evt
);
  logic above, below;
  logic above_q, below_q;
  logic [15:0] occ_ext;

  always_comb begin
    occ_ext = 16'(occ);
    above   = occ_ext > hi_th;
    below   = occ_ext < lo_th;
    hi_evt  = above && !above_q;
    lo_evt  = below && !below_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_q <= 1'b0;
      below_q <= 1'b0;
    end else begin
      above_q <= above;
      below_q <= below;
    end
  end
endmodule

// File: rtl/rs_irq_bank.sv
module rs_irq_bank #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  input  logic         ie_we,
  input  logic [W-1:0] ie_data,
  output logic [W-1:0] sts,
  output logic [W-1:0] ie,
  output logic         irq
);
  logic [W-1:0] sts_q, sts_d;
  logic [W-1:0] ie_q, ie_d;

  // a new event in the clearing cycle wins over the clear
  always_comb begin
    sts_d = sts_q;
    if (clr_we) sts_d = sts_d & ~clr_data;
    sts_d = sts_d | set_vec;
    ie_d  = ie_we ? ie_data : ie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      ie_q  <= '0;
    end else begin
      sts_q <= sts_d;
      ie_q  <= ie_d;
    end
  end

  assign sts = sts_q;
  assign ie  = ie_q;
  assign irq = |(sts_q & ie_q);
endmodule

// File: rtl/ring_stat_ctrl.sv
module ring_stat_ctrl
  import ring_stat_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned SRC_ENTRIES = 16,
  parameter int unsigned DST_ENTRIES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          src_consume,
  input  logic          dst_consume,
  input  logic [3:0]    hw_err,
  output logic          host_irq,
  output logic          err_irq,
  output logic [15:0]   max_dst_len,
  output logic          src_swap_en,
  output logic          dst_swap_en,
  output logic          halted
);
  localparam int unsigned SRC_IW = $clog2(SRC_ENTRIES);
  localparam int unsigned DST_IW = $clog2(DST_ENTRIES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rstn_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rstn_s = rst_sync_q[1];

  // address decode
  function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] off);
    return a == AW'(off);
  endfunction

  logic wr_ctrl, wr_cmd, wr_host_ie, host_clr_we, wr_err_ie, err_clr_we;
  logic wr_src_idx, wr_dst_idx, wr_src_wm, wr_dst_wm;
  always_comb begin
    wr_ctrl     = reg_we && hit(reg_addr, OFF_CTRL);
    wr_cmd      = reg_we && hit(reg_addr, OFF_CMD);
    wr_host_ie  = reg_we && hit(reg_addr, OFF_HOST_IE);
    host_clr_we = reg_we && hit(reg_addr, OFF_HOST_ST);
    wr_err_ie   = reg_we && hit(reg_addr, OFF_ERR_IE);
    err_clr_we  = reg_we && hit(reg_addr, OFF_ERR_ST);
    wr_src_idx  = reg_we && hit(reg_addr, OFF_SRC_WR);
    wr_dst_idx  = reg_we && hit(reg_addr, OFF_DST_WR);
    wr_src_wm   = reg_we && hit(reg_addr, OFF_SRC_WM);
    wr_dst_wm   = reg_we && hit(reg_addr, OFF_DST_WM);
  end

  // control, command and threshold registers
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              halt_req_q, halt_req_d;
  logic              halt_sts_q;
  wm_t               src_wm_q, src_wm_d, dst_wm_q, dst_wm_d;

  always_comb begin
    ctrl_d     = wr_ctrl   ? reg_wdata[CTRL_W-1:0]     : ctrl_q;
    halt_req_d = wr_cmd    ? reg_wdata[CMD_HALT_BIT]   : halt_req_q;
    src_wm_d   = wr_src_wm ? wm_t'(reg_wdata)          : src_wm_q;
    dst_wm_d   = wr_dst_wm ? wm_t'(reg_wdata)          : dst_wm_q;
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) begin
      ctrl_q     <= '0;
      halt_req_q <= 1'b0;
      halt_sts_q <= 1'b0;
      src_wm_q   <= '0;
      dst_wm_q   <= '0;
    end else begin
      ctrl_q     <= ctrl_d;
      halt_req_q <= halt_req_d;
      halt_sts_q <= halt_req_q;
      src_wm_q   <= src_wm_d;
      dst_wm_q   <= dst_wm_d;
    end
  end

  // rings
  logic [SRC_IW-1:0] src_wr, src_rd, src_occ;
  logic [DST_IW-1:0] dst_wr, dst_rd, dst_occ;
  logic src_ovf, src_pop, dst_ovf, dst_pop;

  rs_ring_track #(.ENTRIES(SRC_ENTRIES)) src_ring_i (
    .clk(clk), .rst_n(rstn_s),
    .wr_en(wr_src_idx), .wr_val(reg_wdata[SRC_IW-1:0]),
    .consume(src_consume), .hold(halt_sts_q),
    .wr_idx(src_wr), .rd_idx(src_rd), .occ(src_occ),
    .ovf_evt(src_ovf), .pop_evt(src_pop)
  );

  rs_ring_track #(.ENTRIES(DST_ENTRIES)) dst_ring_i (
    .clk(clk), .rst_n(rstn_s),
    .wr_en(wr_dst_idx), .wr_val(reg_wdata[DST_IW-1:0]),
    .consume(dst_consume), .hold(halt_sts_q),
    .wr_idx(dst_wr), .rd_idx(dst_rd), .occ(dst_occ),
    .ovf_evt(dst_ovf), .pop_evt(dst_pop)
  );

  // threshold crossings
  logic src_hi_evt, src_lo_evt, dst_hi_evt, dst_lo_evt;

  rs_wm_cross #(.IW(SRC_IW)) src_wm_i (
    .clk(clk), .rst_n(rstn_s), .occ(src_occ),
    .lo_th(src_wm_q.lo), .hi_th(src_wm_q.hi),
    .hi_evt(src_hi_evt), .lo_evt(src_lo_evt)
  );

  rs_wm_cross #(.IW(DST_IW)) dst_wm_i (
    .clk(clk), .rst_n(rstn_s), .occ(dst_occ),
    .lo_th(dst_wm_q.lo), .hi_th(dst_wm_q.hi),
    .hi_evt(dst_hi_evt), .lo_evt(dst_lo_evt)
  );

  // status banks
  logic [HOST_W-1:0] host_set, host_sts, host_ie;
  logic [ERR_W-1:0]  err_set, err_sts, err_ie;

  assign host_set = {dst_lo_evt, dst_hi_evt, src_lo_evt, src_hi_evt, src_pop};
  assign err_set  = {hw_err, dst_ovf, src_ovf};

  rs_irq_bank #(.W(HOST_W)) host_bank_i (
    .clk(clk), .rst_n(rstn_s), .set_vec(host_set),
    .clr_we(host_clr_we), .clr_data(reg_wdata[HOST_W-1:0]),
    .ie_we(wr_host_ie), .ie_data(reg_wdata[HOST_W-1:0]),
    .sts(host_sts), .ie(host_ie), .irq(host_irq)
  );

  rs_irq_bank #(.W(ERR_W)) err_bank_i (
    .clk(clk), .rst_n(rstn_s), .set_vec(err_set),
    .clr_we(err_clr_we), .clr_data(reg_wdata[ERR_LSB+ERR_W-1:ERR_LSB]),
    .ie_we(wr_err_ie), .ie_data(reg_wdata[ERR_LSB+ERR_W-1:ERR_LSB]),
    .sts(err_sts), .ie(err_ie), .irq(err_irq)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (hit(reg_addr, OFF_CTRL))    reg_rdata = 32'(ctrl_q);
    if (hit(reg_addr, OFF_CMD)) begin
      reg_rdata[CMD_HALT_BIT] = halt_req_q;
      reg_rdata[CMD_STS_BIT]  = halt_sts_q;
    end
    if (hit(reg_addr, OFF_HOST_IE)) reg_rdata = 32'(host_ie);
    if (hit(reg_addr, OFF_HOST_ST)) reg_rdata = 32'(host_sts);
    if (hit(reg_addr, OFF_ERR_IE))  reg_rdata = 32'(err_ie) << ERR_LSB;
    if (hit(reg_addr, OFF_ERR_ST))  reg_rdata = 32'(err_sts) << ERR_LSB;
    if (hit(reg_addr, OFF_SRC_WR))  reg_rdata = 32'(src_wr);
    if (hit(reg_addr, OFF_DST_WR))  reg_rdata = 32'(dst_wr);
    if (hit(reg_addr, OFF_SRC_RD))  reg_rdata = 32'(src_rd);
    if (hit(reg_addr, OFF_DST_RD))  reg_rdata = 32'(dst_rd);
    if (hit(reg_addr, OFF_SRC_WM))  reg_rdata = src_wm_q;
    if (hit(reg_addr, OFF_DST_WM))  reg_rdata = dst_wm_q;
  end

  assign max_dst_len = ctrl_q[15:0];
  assign src_swap_en = ctrl_q[16];
  assign dst_swap_en = ctrl_q[17];
  assign halted      = halt_sts_q;
endmodule

// File: rtl/ring_stat_ctrl_chk.sv
module ring_stat_ctrl_chk #(
  parameter int unsigned SIW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           halt_req,
  input logic           halt_sts,
  input logic [SIW-1:0] src_rd,
  input logic [SIW-1:0] src_wr,
  input logic [SIW-1:0] src_occ,
  input logic           src_ovf,
  input logic           src_pop,
  input logic [4:0]     host_sts,
  input logic           host_clr_we,
  input logic [31:0]    reg_wdata
);
  // R11
  halt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |=> halt_sts);

  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_sts |=> $stable(src_rd));

  // R3
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ovf |=> $stable(src_wr));

  // R2
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_occ == '0) |=> $stable(src_rd));

  // R6
  copy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |=> host_sts[0]);

  // R7
  sticky_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sts[1] && !(host_clr_we && reg_wdata[1])) |=> host_sts[1]);
endmodule

bind ring_stat_ctrl ring_stat_ctrl_chk #(.SIW(SRC_IW)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .halt_req(halt_req_q), .halt_sts(halt_sts_q),
  .src_rd(src_rd), .src_wr(src_wr), .src_occ(src_occ),
  .src_ovf(src_ovf), .src_pop(src_pop),
  .host_sts(host_sts), .host_clr_we(host_clr_we), .reg_wdata(reg_wdata)
);

// File: tb/ring_stat_ctrl_tb_top.sv
module ring_stat_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        src_consume, dst_consume;
  logic [3:0]  hw_err;
  logic        host_irq, err_irq;
  logic [15:0] max_dst_len;
  logic        src_swap_en, dst_swap_en, halted;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ring_stat_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_consume(src_consume), .dst_consume(dst_consume), .hw_err(hw_err),
    .host_irq(host_irq), .err_irq(err_irq), .max_dst_len(max_dst_len),
    .src_swap_en(src_swap_en), .dst_swap_en(dst_swap_en), .halted(halted)
  );

  // vector: {op, req, addr, data}; op 0 write, 1 read-check, 2 send consume, 3 receive consume
  localparam int NV = 27;
  localparam logic [45:0] VEC [NV] = '{
    {2'd0, 4'd4,  8'h4C, 32'h0002_0005},  // send thresholds lo=2 hi=5
    {2'd1, 4'd5,  8'h30, 32'h0000_0004},  // R5 low crossing from threshold change
    {2'd0, 4'd7,  8'h30, 32'h0000_001F},
    {2'd1, 4'd7,  8'h30, 32'h0000_0000},  // R7 cleared
    {2'd0, 4'd1,  8'h3C, 32'h0000_0003},
    {2'd1, 4'd1,  8'h3C, 32'h0000_0003},  // R1
    {2'd1, 4'd4,  8'h30, 32'h0000_0000},  // R4 no crossing at 3
    {2'd0, 4'd1,  8'h3C, 32'h0000_0007},
    {2'd1, 4'd4,  8'h30, 32'h0000_0002},  // R4 fill 7 above 5
    {2'd2, 4'd2,  8'h00, 32'h0},
    {2'd1, 4'd2,  8'h44, 32'h0000_0001},  // R2
    {2'd1, 4'd6,  8'h30, 32'h0000_0003},  // R6
    {2'd0, 4'd7,  8'h30, 32'h0000_0003},
    {2'd1, 4'd7,  8'h30, 32'h0000_0000},  // R7
    {2'd2, 4'd2,  8'h00, 32'h0},
    {2'd2, 4'd2,  8'h00, 32'h0},
    {2'd2, 4'd2,  8'h00, 32'h0},
    {2'd2, 4'd2,  8'h00, 32'h0},
    {2'd2, 4'd2,  8'h00, 32'h0},
    {2'd1, 4'd2,  8'h44, 32'h0000_0006},  // R2 fill now 1
    {2'd1, 4'd5,  8'h30, 32'h0000_0005},  // R5 fill 1 below 2
    {2'd0, 4'd1,  8'h3C, 32'h0000_0002},  // wrap: fill 12
    {2'd1, 4'd1,  8'h3C, 32'h0000_0002},  // R1 wrapped index accepted
    {2'd1, 4'd4,  8'h30, 32'h0000_0007},  // R4
    {2'd0, 4'd3,  8'h3C, 32'h0000_0006},  // fill would reach 16
    {2'd1, 4'd3,  8'h3C, 32'h0000_0002},  // R3 rejected
    {2'd1, 4'd3,  8'h38, 32'h0000_0020}   // R3 send overflow bit
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_now(input string req, input logic [7:0] a, input logic [31:0] e);
    reg_addr = a;
    #1 check(req, reg_rdata, e);
  endtask

  task automatic do_rd(input string req, input logic [7:0] a, input logic [31:0] e);
    @(negedge clk);
    rd_now(req, a, e);
  endtask

  task automatic cons(input bit dst);
    @(negedge clk);
    if (dst) dst_consume = 1'b1; else src_consume = 1'b1;
    @(negedge clk);
    src_consume = 1'b0; dst_consume = 1'b0;
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    src_consume = 1'b0; dst_consume = 1'b0; hw_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    foreach (VEC[i]) begin end
    for (int a = 8'h10; a <= 8'h50; a += 4) rd_now("R12", 8'(a), 32'h0);
    check("R12", {29'b0, host_irq, err_irq, halted}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      string      tag;
      op  = VEC[i][45:44];
      tag = $sformatf("R%0d", VEC[i][43:40]);
      case (op)
        2'd0: do_wr(VEC[i][39:32], VEC[i][31:0]);
        2'd1: do_rd(tag, VEC[i][39:32], VEC[i][31:0]);
        2'd2: cons(1'b0);
        default: cons(1'b1);
      endcase
    end

    // receive ring: fill 7 of 8, then one more is an overflow (R3)
    do_wr(8'h40, 32'h7);
    do_wr(8'h40, 32'h0);
    do_rd("R3", 8'h40, 32'h7);
    do_rd("R3", 8'h38, 32'h60);
    cons(1'b1);
    do_rd("R2", 8'h48, 32'h1);
    do_rd("R4", 8'h30, 32'h0F);  // receive high (threshold 0) crossed

    // R8 host interrupt masking
    check("R8", {31'b0, host_irq}, 32'h0);
    do_wr(8'h2C, 32'h08);
    check("R8", {31'b0, host_irq}, 32'h1);
    do_wr(8'h30, 32'h08);
    check("R8", {31'b0, host_irq}, 32'h0);
    do_rd("R7", 8'h30, 32'h07);

    // R9 / R8 error path
    check("R8", {31'b0, err_irq}, 32'h0);
    do_wr(8'h34, 32'h20);
    check("R8", {31'b0, err_irq}, 32'h1);
    @(negedge clk); hw_err = 4'b1000;
    @(negedge clk); hw_err = 4'b0001;
    @(negedge clk); hw_err = 4'b0000;
    do_rd("R9", 8'h38, 32'h4E0);
    do_wr(8'h38, 32'h7E0);
    do_rd("R7", 8'h38, 32'h0);
    check("R8", {31'b0, err_irq}, 32'h0);

    // R10 control register
    do_wr(8'h10, 32'hFFFF_FFFF);
    rd_now("R10", 8'h10, 32'h0007_FFFF);
    do_wr(8'h10, 32'h0001_2345);
    check("R10", {13'b0, dst_swap_en, src_swap_en, max_dst_len}, 32'h0001_2345);

    // R11 halt
    do_wr(8'h18, 32'h1);
    rd_now("R11", 8'h18, 32'h1);
    do_rd("R11", 8'h18, 32'h9);
    check("R11", {31'b0, halted}, 32'h1);
    cons(1'b0);
    do_rd("R11", 8'h44, 32'h6);
    do_wr(8'h18, 32'h0);
    do_rd("R11", 8'h18, 32'h0);
    cons(1'b0);
    do_rd("R11", 8'h44, 32'h7);

    // R2 empty receive ring ignores consume
    for (int k = 0; k < 6; k++) cons(1'b1);
    do_rd("R2", 8'h48, 32'h7);
    cons(1'b1);
    do_rd("R2", 8'h48, 32'h7);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule